// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives the serial bit clock for an I2C or SPI master from a fast reference clock. All logic runs in the reference domain. Three stages are chained, each advancing only on a one-cycle tick from the stage before it:

- a coded power-of-two prescaler;
- an optional divide-by-3;
- a phase divider that sets how many ticks the output spends low and how many it spends high.

The output level is registered. One-cycle strobes mark its rising and falling transitions, so the master's shift logic can act on them without a second clock.

Settings are sampled only when a fresh run starts or when an output period closes. A stop request or a dropped enable lets the current period finish first. The output then falls back to its idle low level, and every stage counter is cleared so that the next start has a fixed latency.

Top module: `sclk_gen`

## Requirements
- R1: During and after synchronous reset, `sclk`, `sclk_rise` and `sclk_fall` are 0.
- R2: The rate code `fsel` selects the prescale ratio:
  - code 0 divides the reference by 64;
  - code 1 passes every reference cycle;
  - codes 2 to 6 divide by 2, 4, 8, 16 and 32.
- R3: Rate code 7 is reserved. A run never starts with it, and a run that reaches a period end while `fsel` is 7 goes idle, so `sclk` stays 0 and no strobe occurs.
- R4: With `div3_en` set, each prescaler tick is divided by 3 before it reaches the phase divider. With `div3_en` clear, ticks pass through unchanged.
- R5: With `per_en` clear, `sclk` is low for one stage tick and then high for one stage tick, giving a 50% duty clock.
- R6: With `per_en` set, `sclk` is low for `low_cnt`+1 stage ticks and high for the remainder of `tot_cnt`+1 stage ticks.
- R7: If `low_cnt` is greater than or equal to `tot_cnt`, the low phase is clamped to `tot_cnt` ticks, leaving one high tick. A `tot_cnt` of 0 is treated as 1.
- R8: `sclk_rise` is high for exactly the first cycle in which `sclk` reads 1, and `sclk_fall` for exactly the first cycle in which it reads 0. The two strobes are never high together, and `sclk` never changes without one of them.
- R9: Changes to `fsel`, `div3_en`, `per_en`, `low_cnt` or `tot_cnt` during a run take effect only after the high phase in progress ends.
- R10: A stop or disable never shortens the current period:
  - if `stop` is seen at any point of a period, even for one cycle, the run ends when that period closes;
  - if `enable` is low or `stop` is high when a period closes, the run ends at that point;
  - in both cases `sclk` ends low with a fall strobe;
  - while `stop` is high or `enable` is low, no new run starts.
- R11: A run starts on the first clock edge that sees `enable` high, `stop` low and a valid rate code, with all stage counters cleared. The first rise strobe follows that edge by exactly the low-phase length in reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows runs to start and continue |
| stop | input | 1 | Requests an end of run at the next period end |
| fsel | input | 3 | Prescaler rate code |
| div3_en | input | 1 | Inserts the divide-by-3 stage |
| per_en | input | 1 | Uses the programmed low/total phase counts |
| low_cnt | input | 8 | Low-phase ticks minus one |
| tot_cnt | input | 8 | Period ticks minus one |
| sclk | output | 1 | Registered serial clock level |
| sclk_rise | output | 1 | One-cycle strobe on a low-to-high transition |
| sclk_fall | output | 1 | One-cycle strobe on a high-to-low transition |

## Verification
The bench measures the high and low times of `sclk` in reference cycles for each entry of a settings table, and the entries are chosen to separate the stages:

- every rate code, which shows the prescale mapping;
- the divide-by-3 with and without the phase divider, which shows that the stages multiply;
- asymmetric low/total counts, which show which phase each count governs;
- low counts equal to and above the total, and a zero total, which show the clamp.

Directed runs then cover the following cases:

- a settings change inside a high phase, which separates boundary latching from immediate use;
- a one-cycle stop pulse inside a low phase, which shows that it is held until the period closes and is followed by a fresh start;
- held stop and dropped enable;
- the reserved rate code;
- the exact latency from start to the first rise.

// File: rtl/sclk_pkg.sv
package sclk_pkg;

    localparam int FSEL_W   = 3;
    localparam int CNT_W    = 8;
    localparam int PRE_W    = 6;
    localparam int DIV_MID  = 3;

    localparam logic [FSEL_W-1:0] FSEL_RESERVED = 3'd7;

    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
        logic              div3_en;
        logic              per_en;
        logic [CNT_W-1:0]  low_cnt;
        logic [CNT_W-1:0]  tot_cnt;
    } clk_cfg_t;

    // Terminal count of the prescaler for a rate code.
    function automatic logic [PRE_W-1:0] pre_limit(input logic [FSEL_W-1:0] code);
        logic [PRE_W:0] span;
        if (code == '0)
            span = (PRE_W+1)'(1) << PRE_W;
        else
            span = (PRE_W+1)'(1) << (code - 1'b1);
        return PRE_W'(span - 1'b1);
    endfunction

    function automatic logic fsel_ok(input logic [FSEL_W-1:0] code);
        return code != FSEL_RESERVED;
    endfunction

    // Effective ticks-per-period minus one.
    function automatic logic [CNT_W-1:0] eff_total(input clk_cfg_t c);
        if (!c.per_en)
            return CNT_W'(1);
        else if (c.tot_cnt == '0)
            return CNT_W'(1);
        else
            return c.tot_cnt;
    endfunction

    // Effective low ticks minus one, clamped below the period.
    function automatic logic [CNT_W-1:0] eff_low(input clk_cfg_t c);
        logic [CNT_W-1:0] t;
        t = eff_total(c);
        if (!c.per_en)
            return '0;
        else if (c.low_cnt >= t)
            return t - 1'b1;
        else
            return c.low_cnt;
    endfunction

endpackage

// File: rtl/sclk_prescale.sv
module sclk_prescale
    import sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [FSEL_W-1:0] fsel,
    output logic              tick_o
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;
    logic             at_end;

    assign limit  = pre_limit(fsel);
    assign at_end = (cnt_q >= limit);
    assign tick_o = run && fsel_ok(fsel) && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run || !fsel_ok(fsel))
            cnt_q <= '0;
        else if (at_end)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/sclk_divn.sv
module sclk_divn #(
    parameter int DIV_N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic en,
    input  logic tick_i,
    output logic tick_o
);
    generate
        if (DIV_N > 1) begin : g_div
            localparam int CW = $clog2(DIV_N);
            localparam logic [CW-1:0] LAST = CW'(DIV_N - 1);
            logic [CW-1:0] cnt_q;

            assign tick_o = en ? (tick_i && (cnt_q == LAST)) : tick_i;

            always_ff @(posedge clk) begin
                if (rst || !run || !en)
                    cnt_q <= '0;
                else if (tick_i)
                    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst, run, en};
            assign tick_o    = tick_i;
        end
    endgenerate
endmodule

// File: rtl/sclk_phase.sv
module sclk_phase
    import sclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] total,
    input  logic [CNT_W-1:0] low,
    output logic             wrap_o,
    output logic             sclk_o,
    output logic             rise_o,
    output logic             fall_o
);
    logic [CNT_W-1:0] ph_q;
    logic [CNT_W-1:0] ph_n;
    logic             high_n;

    assign wrap_o = run && tick_i && (ph_q >= total);
    assign ph_n   = (ph_q >= total) ? '0 : ph_q + 1'b1;
    assign high_n = (ph_n > low);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q   <= '0;
            sclk_o <= 1'b0;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else if (tick_i) begin
            ph_q   <= ph_n;
            sclk_o <= high_n;
            rise_o <= high_n && !sclk_o;
            fall_o <= !high_n && sclk_o;
        end else begin
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
    import sclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              stop,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              div3_en,
    input  logic              per_en,
    input  logic [CNT_W-1:0]  low_cnt,
    input  logic [CNT_W-1:0]  tot_cnt,
    output logic              sclk,
    output logic              sclk_rise,
    output logic              sclk_fall
);
    clk_cfg_t cfg_in;
    clk_cfg_t act_q;
    logic     run_q;
    logic     stop_pend_q;
    logic     start;
    logic     wrap;
    logic     tick_pre;
    logic     tick_mid;
    logic     end_run;

    assign cfg_in = '{fsel: fsel, div3_en: div3_en, per_en: per_en,
                      low_cnt: low_cnt, tot_cnt: tot_cnt};

    assign start   = !run_q && enable && !stop && fsel_ok(fsel);
    assign end_run = stop_pend_q || stop || !enable || !fsel_ok(fsel);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q       <= 1'b0;
            act_q       <= '0;
            stop_pend_q <= 1'b0;
        end else if (!run_q) begin
            stop_pend_q <= 1'b0;
            if (start) begin
                run_q <= 1'b1;
                act_q <= cfg_in;
            end
        end else if (wrap) begin
            stop_pend_q <= 1'b0;
            if (end_run)
                run_q <= 1'b0;
            else
                act_q <= cfg_in;
        end else if (stop) begin
            stop_pend_q <= 1'b1;
        end
    end

    sclk_prescale u_pre (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .fsel   (act_q.fsel),
        .tick_o (tick_pre)
    );

    sclk_divn #(.DIV_N(DIV_MID)) u_div3 (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .en     (act_q.div3_en),
        .tick_i (tick_pre),
        .tick_o (tick_mid)
    );

    sclk_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .run    (run_q),
        .tick_i (tick_mid),
        .total  (eff_total(act_q)),
        .low    (eff_low(act_q)),
        .wrap_o (wrap),
        .sclk_o (sclk),
        .rise_o (sclk_rise),
        .fall_o (sclk_fall)
    );
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk (
    input logic clk,
    input logic rst,
    input logic sclk,
    input logic rise,
    input logic fall,
    input logic run
);
    // R8: rise strobe marks the first high cycle
    p_rise_marks_high_r8: assert property (@(posedge clk) disable iff (rst)
        rise |-> (sclk && !$past(sclk)));

    // R8: fall strobe marks the first low cycle
    p_fall_marks_low_r8: assert property (@(posedge clk) disable iff (rst)
        fall |-> (!sclk && $past(sclk)));

    // R8: every level change carries a strobe
    p_change_strobed_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sclk) |-> (rise || fall));

    // R8: strobes exclusive
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rise, fall}));

    // R10: an idle generator holds the low level
    p_idle_low_r10: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!sclk && !rise));

    // R10: a run only ends on a completed period, with a fall
    p_end_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> fall);
endmodule

bind sclk_gen sclk_gen_chk u_chk (
    .clk  (clk),
    .rst  (rst),
    .sclk (sclk),
    .rise (sclk_rise),
    .fall (sclk_fall),
    .run  (run_q)
);

// File: tb/sclk_gen_tb.sv
`timescale 1ns/1ps
module sclk_gen_tb;
    import sclk_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst, enable, stop, div3_en, per_en;
    logic [FSEL_W-1:0] fsel;
    logic [CNT_W-1:0]  low_cnt, tot_cnt;
    logic              sclk, sclk_rise, sclk_fall;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;

    sclk_gen u_dut (
        .clk(clk), .rst(rst), .enable(enable), .stop(stop), .fsel(fsel),
        .div3_en(div3_en), .per_en(per_en), .low_cnt(low_cnt), .tot_cnt(tot_cnt),
        .sclk(sclk), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall)
    );

    // Settings table: rate code, div3, phase divider, low, total, expected high/low cycles
    localparam int NV = 12;
    localparam int V_FS[NV] = '{1, 2, 3, 1, 4, 1, 1, 1, 1, 0, 6, 5};
    localparam int V_D3[NV] = '{0, 0, 1, 0, 0, 1, 0, 0, 0, 0, 1, 0};
    localparam int V_PE[NV] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 0, 1, 0};
    localparam int V_LO[NV] = '{0, 0, 0, 1, 0, 3, 9, 4, 5, 0, 0, 0};
    localparam int V_TO[NV] = '{0, 0, 0, 5, 3, 4, 4, 4, 0, 0, 1, 0};
    localparam int V_HI[NV] = '{1, 2, 12, 4, 24, 3, 1, 1, 1, 64, 96, 16};
    localparam int V_LW[NV] = '{1, 2, 12, 2, 8, 12, 4, 4, 1, 64, 96, 16};
    localparam string V_RQ[NV] = '{"R5", "R2", "R4", "R6", "R2/R6", "R4/R6",
                                   "R7", "R7", "R7", "R2", "R4/R2", "R2"};

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input int f, input int d3, input int pe, input int lo, input int to);
        fsel    = FSEL_W'(f);
        div3_en = d3[0];
        per_en  = pe[0];
        low_cnt = CNT_W'(lo);
        tot_cnt = CNT_W'(to);
    endtask

    task automatic do_reset();
        rst = 1'b1; enable = 1'b0; stop = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Counts negedges from now until the strobe appears
    task automatic wait_rise(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sclk_rise && n < 3000);
    endtask

    task automatic wait_fall(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!sclk_fall && n < 3000);
    endtask

    task automatic count_rises(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (sclk_rise || sclk) n++;
        end
    endtask

    initial begin
        int n, hi, lo;
        apply(1, 0, 0, 0, 0);
        rst = 1'b1; enable = 1'b0; stop = 1'b0;
        @(negedge clk); @(negedge clk);
        // R1: reset state
        check("R1", "sclk in reset", int'(sclk), 0);
        check("R1", "strobes in reset", int'(sclk_rise | sclk_fall), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "sclk after reset", int'(sclk), 0);

        // Table walk: R2 R4 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            do_reset();
            apply(V_FS[v], V_D3[v], V_PE[v], V_LO[v], V_TO[v]);
            enable = 1'b1;
            wait_rise(n);
            check("R8", "level at rise strobe", int'(sclk), 1);
            wait_fall(hi);
            check(V_RQ[v], $sformatf("row %0d high cycles", v), hi, V_HI[v]);
            wait_rise(lo);
            check(V_RQ[v], $sformatf("row %0d low cycles", v), lo, V_LW[v]);
        end

        // R3: reserved rate code never runs
        do_reset();
        apply(7, 0, 0, 0, 0);
        enable = 1'b1;
        count_rises(300, n);
        check("R3", "activity with code 7", n, 0);

        // R3: switching to code 7 mid-run idles at the period end
        do_reset();
        apply(1, 0, 1, 1, 5);
        enable = 1'b1;
        wait_rise(n);
        apply(7, 0, 1, 1, 5);
        wait_fall(hi);
        check("R3", "high cycles before idling", hi, 4);
        count_rises(100, n);
        check("R3", "activity after code 7 latched", n, 0);

        // R9: change inside a high phase applies after it
        do_reset();
        apply(1, 0, 1, 1, 5);
        enable = 1'b1;
        wait_rise(n);
        apply(1, 0, 1, 0, 1);
        wait_fall(hi);
        check("R9", "old high phase kept", hi, 4);
        wait_rise(lo);
        check("R9", "new low phase", lo, 1);
        wait_fall(hi);
        check("R9", "new high phase", hi, 1);

        // R10: one-cycle stop pulse in a low phase ends that period, then a fresh run
        do_reset();
        apply(1, 0, 1, 1, 5);
        enable = 1'b1;
        wait_fall(n);
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
        wait_rise(lo);
        check("R10", "low cycles of period with pulse", lo + 1, 2);
        wait_fall(hi);
        check("R10", "high cycles of period with pulse", hi, 4);
        wait_rise(lo);
        check("R10", "low cycles incl idle gap", lo, 3);

        // R10: held stop finishes the period, then stays idle
        wait_fall(n);
        wait_rise(n);
        stop = 1'b1;
        wait_fall(hi);
        check("R10", "high cycles under held stop", hi, 4);
        count_rises(100, n);
        check("R10", "activity while stop held", n, 0);

        // R11: fresh start with /4 prescale and cleared counters
        apply(3, 0, 1, 1, 5);
        @(negedge clk);
        stop = 1'b0;
        wait_rise(n);
        check("R11", "cycles from release to first rise", n, 9);

        // R10: dropped enable finishes the period, then stays idle
        wait_fall(n);
        wait_rise(n);
        enable = 1'b0;
        wait_fall(hi);
        check("R10", "high cycles after disable", hi, 16);
        count_rises(200, n);
        check("R10", "activity while disabled", n, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule